// File: doc/BRIEF.md
# MII Management Controller with Status Scan

This block is the host side of a two-wire PHY management link. It turns single commands into complete management frames on a divided clock (`mdc`) and a shared data line (`mdio_o`, `mdio_oe`, `mdio_i`). A write frame carries 16 bits of control data to a chosen register of a chosen PHY. A read frame fetches 16 bits back. Both frames use the standard clause-22 layout.

The third command is a status scan. The controller reads status register 1 of the selected PHY in back-to-back frames until the host withdraws the command. After every scan frame it derives a link-fail flag from the link bit of the returned word. A not-valid qualifier tells the host when `link_fail` and `rd_data` cannot yet be trusted.

A command is sampled when `cmd_we` is high. The PHY address, register address, write data and MDC half period are captured at that moment, so the host may change them while the frame runs.

Top module: `mdio_scan_ctrl`

## Requirements
- R1: `cmd` is one-hot and is accepted only on a cycle where `cmd_we` is high and `busy` is low: `3'b001` starts a write, `3'b010` a read, `3'b100` a scan. Any other value, including zero or several bits set, is ignored and `busy` stays low.
- R2: A frame is 64 MDC periods long, sent first bit first: 32 ones, start `01`, opcode (`10` read, `01` write), 5-bit PHY address MSB first, 5-bit register address MSB first, turnaround (`10` on write), then 16 data bits MSB first.
- R3: MDC has a period of 2×`mdc_half` system clocks, with 0 treated as 1. It is low while idle and rises `mdc_half` clocks after the accepting edge. Frame bit k is driven from clock k×period to (k+1)×period after that edge, so the data line changes only with the MDC falling edge.
- R4: On a read, `mdio_oe` drops at the turnaround (bit 46) and stays low until the frame ends. On a write it stays high for the whole frame.
- R5: The data line is sampled on each MDC rising edge of bits 48 to 63. `rd_data` is loaded once, at the end of each read or scan frame. An absent PHY leaves the line pulled high and so reads back 16'hFFFF. `done` pulses for one clock at the end of every frame.
- R6: `busy` rises on the edge that accepts a command and, for a single frame, falls exactly 64 MDC periods later, on the same edge that raises `done`.
- R7: A scan reads register 1 of the selected PHY in back-to-back frames with `busy` held high. A command write with `cmd[2]` clear during a scan ends it after the frame in progress.
- R8: At the end of each scan frame, `link_fail` becomes the inverse of bit 2 of the status word just read.
- R9: `nvalid` is high after reset and is set again when a scan is accepted. It clears at the end of the first scan frame. Plain reads and writes change neither `nvalid` nor `link_fail`.
- R10: While `busy` is high, commands other than a scan stop are ignored. The values captured at acceptance are used for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command strobe |
| cmd | input | 3 | One-hot command: write, read, scan |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address (not used for scan) |
| wr_data | input | 16 | Data for a write frame |
| mdc_half | input | HALF_W | MDC half period in system clocks |
| mdio_i | input | 1 | Sampled management data line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Driven management data |
| mdio_oe | output | 1 | Output enable for the data line |
| rd_data | output | 16 | Last word read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock end-of-frame pulse |
| link_fail | output | 1 | Link down, as seen by the last scan frame |
| nvalid | output | 1 | Scan results not yet valid |

## Verification
The assertions rely on the host keeping `mdc_half` at one or more clocks, which makes every frame at least 128 clocks long. They also rely on the line returning a defined level on every sampled edge. The bench uses only half periods from 0 to 3. Its PHY model pulls the line high whenever it does not answer. It changes the modelled link state only between operations or in the middle of a scan, and the new value takes effect at the next frame start. Scan stop commands are issued well away from frame boundaries.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam logic [4:0] STATUS_REG = 5'd1;
  localparam int LINK_BIT  = 2;

  typedef enum logic [2:0] {
    CMD_WRITE = 3'b001,
    CMD_READ  = 3'b010,
    CMD_SCAN  = 3'b100
  } cmd_e;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } frame_req_t;
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise_evt,
  output logic              fall_evt
);
  logic [HALF_W-1:0] cnt;
  logic              wrap;

  assign wrap     = run && (cnt == half - 1'b1);
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  frame_req_t  req,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        frame_end,
  output logic [15:0] rx_word
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  logic [IDX_W-1:0]     idx, nxt;
  logic [FRAME_LEN-1:0] frame;

  always_comb begin
    frame = {32'hFFFF_FFFF, 2'b01,
             req.rd ? 2'b10 : 2'b01,
             req.phy, req.regad,
             req.rd ? 2'b11 : 2'b10,
             req.rd ? 16'hFFFF : req.wdata};
  end

  assign nxt       = idx + 1'b1;
  assign frame_end = fall_evt && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rx_word <= '0;
    end else begin
      if (load) begin
        idx     <= '0;
        mdio_o  <= frame[FRAME_LEN-1];
        mdio_oe <= 1'b1;
      end else if (frame_end) begin
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b0;
      end else if (fall_evt) begin
        idx     <= nxt;
        mdio_o  <= frame[LAST - nxt];
        mdio_oe <= !(req.rd && (nxt >= IDX_W'(TA_POS)));
      end
      if (rise_evt && (idx >= IDX_W'(DATA_POS)))
        rx_word <= {rx_word[14:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_scan_ctrl.sv
module mdio_scan_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [2:0]        cmd,
  input  logic [4:0]        phy_addr,
  input  logic [4:0]        reg_addr,
  input  logic [15:0]       wr_data,
  input  logic [HALF_W-1:0] mdc_half,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [15:0]       rd_data,
  output logic              busy,
  output logic              done,
  output logic              link_fail,
  output logic              nvalid
);
  frame_req_t        req_q;
  logic [HALF_W-1:0] half_q;
  logic              is_scan, scan_run;
  logic              cmd_ok, accept, stop_req, load;
  logic              rise_evt, fall_evt, frame_end;
  logic [15:0]       rx_word;

  assign cmd_ok   = (cmd == CMD_WRITE) || (cmd == CMD_READ) || (cmd == CMD_SCAN);
  assign accept   = cmd_we && !busy && cmd_ok;
  assign stop_req = cmd_we && busy && scan_run && !cmd[2];
  assign load     = accept || (frame_end && scan_run);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= '0;
      half_q    <= HALF_W'(1);
      busy      <= 1'b0;
      is_scan   <= 1'b0;
      scan_run  <= 1'b0;
      done      <= 1'b0;
      rd_data   <= '0;
      link_fail <= 1'b0;
      nvalid    <= 1'b1;
    end else begin
      done <= frame_end;
      if (frame_end) begin
        if (req_q.rd) rd_data <= rx_word;
        if (is_scan) begin
          link_fail <= ~rx_word[LINK_BIT];
          nvalid    <= 1'b0;
        end
        if (!scan_run) begin
          busy    <= 1'b0;
          is_scan <= 1'b0;
        end
      end
      if (stop_req) scan_run <= 1'b0;
      if (accept) begin
        busy        <= 1'b1;
        req_q.rd    <= (cmd != CMD_WRITE);
        req_q.phy   <= phy_addr;
        req_q.regad <= cmd[2] ? STATUS_REG : reg_addr;
        req_q.wdata <= wr_data;
        half_q      <= (mdc_half == '0) ? HALF_W'(1) : mdc_half;
        is_scan     <= cmd[2];
        scan_run    <= cmd[2];
        if (cmd[2]) nvalid <= 1'b1;
      end
    end
  end

  mdc_divider #(.HALF_W(HALF_W)) i_div (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .half     (half_q),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_engine i_eng (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .req       (req_q),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .frame_end (frame_end),
    .rx_word   (rx_word)
  );
endmodule

// File: rtl/mdio_scan_ctrl_chk.sv
module mdio_scan_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdio_oe,
  input logic [15:0] rd_data,
  input logic        link_fail,
  input logic        nvalid
);
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  a_r3_mdc_low_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
  a_r4_oe_only_busy: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  a_r5_rd_data_at_end: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> done);
  a_r8_link_at_end: assert property (@(posedge clk) disable iff (rst)
    !$stable(link_fail) |-> done);
  a_r9_nvalid_clears_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(nvalid) |-> done);
endmodule

bind mdio_scan_ctrl mdio_scan_ctrl_chk i_chk (.*);

// File: tb/test_mdio_scan_ctrl.sv
module test_mdio_scan_ctrl;
  localparam int CLK_P = 10;
  localparam int HW = 8;
  localparam logic [4:0] BENCH_PHY = 5'd3;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_we = 1'b0;
  logic [2:0] cmd = 3'b000;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [HW-1:0] mdc_half = HW'(1);
  logic mdio_i = 1'b1;
  logic mdc, mdio_o, mdio_oe, busy, done, link_fail, nvalid;
  logic [15:0] rd_data;
  bit link_up = 1'b1;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  mdio_scan_ctrl #(.HALF_W(HW)) i_mdio_scan_ctrl (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd(cmd), .phy_addr(phy_addr),
    .reg_addr(reg_addr), .wr_data(wr_data), .mdc_half(mdc_half), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data), .busy(busy),
    .done(done), .link_fail(link_fail), .nvalid(nvalid));

  function automatic logic [15:0] resp_of(input logic [4:0] p, input logic [4:0] r, input bit up);
    if (p != BENCH_PHY) return 16'hFFFF;
    if (r == 5'd1) return 16'h7849 | (up ? 16'h0004 : 16'h0000);
    return 16'hA500 ^ {11'b0, r};
  endfunction

  // behavioural reference model
  int m_j = 0, m_div = 2, m_half = 1;
  bit m_busy = 0, m_read = 0, m_isscan = 0, m_scanrun = 0, m_done = 0, m_lf = 0, m_nv = 1;
  logic [15:0] m_rd = '0, m_resp = '1;
  logic [63:0] m_frame = '1;
  logic [4:0] m_phy = '0, m_reg = '0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_j = 0; m_busy = 0; m_read = 0; m_isscan = 0; m_scanrun = 0;
      m_done = 0; m_lf = 0; m_nv = 1; m_rd = '0;
    end else begin
      bit bp, sp;
      bp = m_busy; sp = m_scanrun; m_done = 0;
      if (m_busy) begin
        m_j++;
        if (m_j == 64 * m_div) begin
          m_done = 1;
          if (m_read) m_rd = m_resp;
          if (m_isscan) begin m_lf = ~m_resp[2]; m_nv = 0; end
          if (sp) begin m_j = 0; m_resp = resp_of(m_phy, m_reg, link_up); end
          else begin m_busy = 0; m_isscan = 0; end
        end
      end
      if (cmd_we) begin
        if (!bp && (cmd == 3'b001 || cmd == 3'b010 || cmd == 3'b100)) begin
          m_busy = 1; m_j = 0; m_read = (cmd != 3'b001);
          m_isscan = cmd[2]; m_scanrun = cmd[2];
          m_phy = phy_addr; m_reg = cmd[2] ? 5'd1 : reg_addr;
          m_half = (mdc_half == 0) ? 1 : int'(mdc_half); m_div = 2 * m_half;
          m_frame = {32'hFFFF_FFFF, 2'b01, m_read ? 2'b10 : 2'b01, m_phy, m_reg,
                     m_read ? 2'b11 : 2'b10, m_read ? 16'hFFFF : wr_data};
          m_resp = resp_of(m_phy, m_reg, link_up);
          if (cmd[2]) m_nv = 1;
        end else if (bp && sp && !cmd[2]) m_scanrun = 0;
      end
    end
  end

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison and PHY model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      int b;
      bit e_mdc, e_oe;
      b = m_j / m_div;
      e_mdc = m_busy && ((m_j % m_div) >= m_half);
      e_oe  = m_busy && !(m_read && b >= 46);
      vectors++;
      cmp("R3 mdc", 16'(mdc), 16'(e_mdc));
      cmp("R4 mdio_oe", 16'(mdio_oe), 16'(e_oe));
      if (e_oe) cmp("R2 mdio_o", 16'(mdio_o), 16'(m_frame[63-b]));
      cmp("R6 busy", 16'(busy), 16'(m_busy));
      cmp("R5 done", 16'(done), 16'(m_done));
      cmp("R5 rd_data", rd_data, m_rd);
      cmp("R8 link_fail", 16'(link_fail), 16'(m_lf));
      cmp("R9 nvalid", 16'(nvalid), 16'(m_nv));
      mdio_i <= (m_busy && b >= 48 && b < 64) ? m_resp[63-b] : 1'b1;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    cmp(tag, act, exp);
  endtask

  task automatic issue(input logic [2:0] c, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d, input int h);
    @(negedge clk);
    cmd = c; phy_addr = p; reg_addr = r; wr_data = d; mdc_half = HW'(h); cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0; cmd = 3'b000;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic summary();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 R9: reset state
    check("R6 reset busy", 16'(busy), 16'h0);
    check("R9 reset nvalid", 16'(nvalid), 16'h1);
    check("R3 reset mdc", 16'(mdc), 16'h0);
    rst = 1'b0;
    // R2: write frame, half period 2
    issue(3'b001, BENCH_PHY, 5'd5, 16'hA5C3, 2);
    wait_idle();
    // R5: read from present PHY, half period 1
    issue(3'b010, BENCH_PHY, 5'd2, 16'h0000, 1);
    wait_idle();
    @(negedge clk);
    check("R5 read present", rd_data, 16'hA502);
    // R5: absent PHY reads all ones, half period 3
    issue(3'b010, 5'd9, 5'd2, 16'h0000, 3);
    wait_idle();
    check("R5 read absent", rd_data, 16'hFFFF);
    // R1: illegal commands ignored
    issue(3'b011, BENCH_PHY, 5'd2, 16'h0, 1);
    check("R1 cmd 011 ignored", 16'(busy), 16'h0);
    issue(3'b000, BENCH_PHY, 5'd2, 16'h0, 1);
    check("R1 cmd 000 ignored", 16'(busy), 16'h0);
    issue(3'b111, BENCH_PHY, 5'd2, 16'h0, 1);
    check("R1 cmd 111 ignored", 16'(mdio_oe), 16'h0);
    // R10: read during write ignored; half 0 treated as 1 (R3)
    issue(3'b001, BENCH_PHY, 5'd7, 16'h1234, 0);
    repeat (10) @(negedge clk);
    issue(3'b010, BENCH_PHY, 5'd4, 16'h0, 3);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R10 read ignored", rd_data, 16'hFFFF);
    check("R10 still idle", 16'(busy), 16'h0);
    // R7 R8 R9: scan
    link_up = 1'b1;
    issue(3'b100, BENCH_PHY, 5'd0, 16'h0, 1);
    check("R9 nvalid at scan start", 16'(nvalid), 16'h1);
    wait_done();
    check("R9 nvalid after first", 16'(nvalid), 16'h0);
    check("R8 link up", 16'(link_fail), 16'h0);
    link_up = 1'b0;
    wait_done();
    wait_done();
    check("R8 link down", 16'(link_fail), 16'h1);
    check("R7 busy during scan", 16'(busy), 16'h1);
    repeat (20) @(negedge clk);
    issue(3'b000, 5'd0, 5'd0, 16'h0, 1);
    wait_idle();
    check("R7 scan stopped", 16'(busy), 16'h0);
    // R9: plain read leaves scan flags alone
    link_up = 1'b1;
    issue(3'b010, BENCH_PHY, 5'd1, 16'h0, 1);
    wait_idle();
    check("R9 read keeps link_fail", 16'(link_fail), 16'h1);
    check("R9 read keeps nvalid", 16'(nvalid), 16'h0);
    check("R5 status read", rd_data, 16'h784D);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule